// File: doc/BRIEF.md
# Multi-Level Ready-List Thread Scheduler

This block picks which hardware thread runs next on a multithreaded core. It tracks up to sixteen threads at four fixed urgency levels. Levels 0 to 2 carry application threads and level 3 holds the idle thread, with level 0 the most urgent. Each level has its own ready list, kept as a doubly linked list with a head and a tail pointer. A fifth list of the same form holds blocked threads. A thread manager sends one command per cycle: enqueue a thread at a given level, block a ready thread, or unblock a waiting one. Each command completes in one clock cycle, however many threads are present.

The block always shows the thread that the next context switch would dispatch in a registered, 32-bit next-thread output. It switches only when the programmable time-slice runs out, or when an external interrupt asks for an immediate switch. A newly ready urgent thread therefore waits for the current slice to end. At each switch the dispatched thread moves from the head to the tail of its level, so threads that share a level take turns one slice at a time. Thread IDs are 0 to 15, and the reserved pointer value 0x1F means "no thread".

Top module: `prio_list_sched`

## Requirements
- R1: After a synchronous reset, all lists are empty, `next_tid` and `run_tid` read 0x1F, `ctx_switch` and `dup_err` are low, and the slice length is 8.
- R2: An enqueue (`cmd_op` = 2'b00) appends the thread at the tail of the level given by `cmd_prio`, so threads of one level are dispatched in arrival order.
- R3: The selected thread is the head of the lowest-numbered non-empty level. Empty levels are skipped, and with every ready list empty the selection is 0x1F.
- R4: `next_tid` is a registered value, zero-extended in bits 31:5. After every clock edge it equals the selection computed from the lists as that edge left them.
- R5: A context switch happens at the first edge at which the slice counter is zero. `ctx_switch` is high for the cycle after that edge, `run_tid` takes the value `next_tid` showed, and the counter reloads to slice length minus 1. A length of 0 acts as 1. `cfg_we` loads a new length, which is used from the next reload on.
- R6: At each switch the dispatched thread moves from the head to the tail of its level. This is round-robin within a level.
- R7: A newly ready, more urgent thread does not cause a switch before the slice expires. An `irq` high at an edge forces a switch at that edge.
- R8: A block (`cmd_op` = 2'b01) of a ready thread unlinks it from any position in its list and appends it to the wait list. A blocked thread is never selected. A block of a thread that is not ready is ignored.
- R9: An unblock (`cmd_op` = 2'b10) of a waiting thread moves it to the tail of the level it was enqueued with. An unblock of a thread that is not waiting is ignored.
- R10: An enqueue of a thread already in any list changes no list and sets `dup_err`, which stays high until reset.
- R11: An edge at which `cmd_valid` is high never switches. A due switch waits for the next edge without a command.
- R12: `cmd_op` = 2'b11 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 00 enqueue, 01 block, 10 unblock, 11 none |
| cmd_tid | input | 4 | Thread the command acts on |
| cmd_prio | input | 2 | Level for an enqueue |
| cfg_we | input | 1 | Load a new slice length |
| cfg_slice | input | 8 | Slice length in cycles |
| irq | input | 1 | Force a switch at this edge |
| next_tid | output | 32 | Thread the next switch dispatches (0x1F: none) |
| run_tid | output | 5 | Thread dispatched at the last switch (0x1F: none) |
| ctx_switch | output | 1 | One-cycle pulse after a switch |
| dup_err | output | 1 | Sticky duplicate-enqueue flag |

## Verification
The assertions assume that the manager issues at most one command per cycle and that `irq` only matters at edges free of a command. Under that assumption, a dispatch always takes the head of some list, and `run_tid` after a switch always matches the preview. The stimulus drives commands only at the falling edge. It combines directed sequences (urgent arrival mid-slice, interrupt, mid-list block, unblock, duplicate enqueue, zero slice length) with a long pseudo-random command stream. That stream includes ignored blocks, ignored unblocks and duplicates, so every input combination the assertions accept is reached.

// File: rtl/tsched_pkg.sv
package tsched_pkg;
  typedef enum logic [1:0] {
    OP_ENQ = 2'b00,
    OP_BLK = 2'b01,
    OP_UNB = 2'b10,
    OP_NOP = 2'b11
  } op_e;
endpackage

// File: rtl/tsched_lists.sv
// Five doubly linked lists (NP ready levels plus one wait list) over NT slots.
// One unlink and one append per cycle, applied in that order.
module tsched_lists #(
  parameter int NT = 16,
  parameter int NP = 4,
  localparam int IW = $clog2(NT),
  localparam int PW = IW + 1,
  localparam int LN = NP + 1,
  localparam int LW = $clog2(NP + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          unl_en,
  input  logic [IW-1:0] unl_id,
  input  logic          app_en,
  input  logic [IW-1:0] app_id,
  input  logic [LW-1:0] app_list,
  output logic [PW-1:0] hd_o [NP],
  output logic [PW-1:0] hn_o [NP],
  output logic [LW-1:0] loc_o [NT]
);
  localparam logic [PW-1:0] NULLP = {PW{1'b1}};
  localparam logic [LW-1:0] NOLOC = {LW{1'b1}};

  logic [PW-1:0] nx_q [NT], nx_n [NT];
  logic [PW-1:0] pv_q [NT], pv_n [NT];
  logic [PW-1:0] hd_q [LN], hd_n [LN];
  logic [PW-1:0] tl_q [LN], tl_n [LN];
  logic [LW-1:0] lc_q [NT], lc_n [NT];
  logic [PW-1:0] p, n, t;
  logic [LW-1:0] ul;

  always_comb begin
    nx_n = nx_q; pv_n = pv_q; hd_n = hd_q; tl_n = tl_q; lc_n = lc_q;
    p = NULLP; n = NULLP; t = NULLP; ul = '0;
    if (unl_en) begin
      ul = lc_q[unl_id];
      p  = pv_q[unl_id];
      n  = nx_q[unl_id];
      if (p == NULLP) hd_n[ul] = n; else nx_n[p[IW-1:0]] = n;
      if (n == NULLP) tl_n[ul] = p; else pv_n[n[IW-1:0]] = p;
      nx_n[unl_id] = NULLP;
      pv_n[unl_id] = NULLP;
      lc_n[unl_id] = NOLOC;
    end
    if (app_en) begin
      t = tl_n[app_list];
      nx_n[app_id] = NULLP;
      pv_n[app_id] = t;
      if (t == NULLP) hd_n[app_list] = {1'b0, app_id};
      else            nx_n[t[IW-1:0]] = {1'b0, app_id};
      tl_n[app_list] = {1'b0, app_id};
      lc_n[app_id]   = app_list;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NT; i++) begin
        nx_q[i] <= NULLP; pv_q[i] <= NULLP; lc_q[i] <= NOLOC;
      end
      for (int l = 0; l < LN; l++) begin
        hd_q[l] <= NULLP; tl_q[l] <= NULLP;
      end
    end else begin
      nx_q <= nx_n; pv_q <= pv_n; lc_q <= lc_n;
      hd_q <= hd_n; tl_q <= tl_n;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NP; g++) begin : g_out
      assign hd_o[g] = hd_q[g];
      assign hn_o[g] = hd_n[g];
    end
    for (g = 0; g < LN; g++) begin : g_chk
      // R2: a list is empty at both ends or at neither
      a_r2_ends_agree: assert property (@(posedge clk) disable iff (rst)
        (hd_q[g] == NULLP) == (tl_q[g] == NULLP));
    end
  endgenerate
  assign loc_o = lc_q;
endmodule

// File: rtl/tsched_pick.sv
// Head of the most urgent non-empty level.
module tsched_pick #(
  parameter int NP = 4,
  parameter int PW = 5,
  localparam int PRW = $clog2(NP)
) (
  input  logic [PW-1:0]  heads [NP],
  output logic [PW-1:0]  sel,
  output logic [PRW-1:0] sel_lvl
);
  always_comb begin
    sel = {PW{1'b1}};
    sel_lvl = '0;
    for (int l = NP - 1; l >= 0; l--) begin
      if (heads[l] != {PW{1'b1}}) begin
        sel = heads[l];
        sel_lvl = PRW'(l);
      end
    end
  end
endmodule

// File: rtl/tsched_slice.sv
// Programmable time-slice down-counter.
module tsched_slice #(
  parameter int CW = 8,
  parameter logic [CW-1:0] DEF_SLICE = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_len,
  input  logic          reload,
  output logic          expired
);
  logic [CW-1:0] len_q, cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= DEF_SLICE;
      cnt_q <= '0;
    end else begin
      if (cfg_we) len_q <= cfg_len;
      if (reload) cnt_q <= (len_q == '0) ? '0 : len_q - 1'b1;
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end
  assign expired = (cnt_q == '0);

  // R5: between reloads the counter falls by one per cycle
  a_r5_countdown: assert property (@(posedge clk) disable iff (rst)
    (!reload && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/prio_list_sched.sv
module prio_list_sched #(
  parameter int NT = 16,
  parameter int NP = 4,
  parameter int CW = 8,
  parameter int NEXT_W = 32,
  parameter logic [CW-1:0] DEF_SLICE = 8,
  localparam int IW = $clog2(NT),
  localparam int PW = IW + 1,
  localparam int PRW = $clog2(NP),
  localparam int LW = $clog2(NP + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [IW-1:0]     cmd_tid,
  input  logic [PRW-1:0]    cmd_prio,
  input  logic              cfg_we,
  input  logic [CW-1:0]     cfg_slice,
  input  logic              irq,
  output logic [NEXT_W-1:0] next_tid,
  output logic [PW-1:0]     run_tid,
  output logic              ctx_switch,
  output logic              dup_err
);
  import tsched_pkg::*;
  localparam logic [PW-1:0] NULLP = {PW{1'b1}};
  localparam logic [LW-1:0] NOLOC = {LW{1'b1}};
  localparam logic [LW-1:0] WAITL = LW'(NP);

  logic [PW-1:0]  hd [NP], hn [NP];
  logic [LW-1:0]  loc [NT];
  logic [PRW-1:0] prio_q [NT];
  logic [PW-1:0]  sel_cur, sel_nxt;
  logic [PRW-1:0] lvl_cur, lvl_nxt;
  logic           expired, do_sw, rot;
  logic           enq_ok, enq_dup, blk_ok, unb_ok;
  logic           unl_en, app_en;
  logic [IW-1:0]  mv_id;
  logic [LW-1:0]  app_list, cmd_loc;
  logic [PW-1:0]  next_q, run_q;
  logic           sw_q, err_q;
  op_e            op;

  assign op      = op_e'(cmd_op);
  assign cmd_loc = loc[cmd_tid];
  assign enq_ok  = cmd_valid && op == OP_ENQ && cmd_loc == NOLOC;
  assign enq_dup = cmd_valid && op == OP_ENQ && cmd_loc != NOLOC;
  assign blk_ok  = cmd_valid && op == OP_BLK && cmd_loc < WAITL;
  assign unb_ok  = cmd_valid && op == OP_UNB && cmd_loc == WAITL;

  assign do_sw = (expired || irq) && !cmd_valid;
  assign rot   = do_sw && sel_cur != NULLP;

  assign unl_en = rot || blk_ok || unb_ok;
  assign app_en = rot || enq_ok || blk_ok || unb_ok;
  assign mv_id  = rot ? sel_cur[IW-1:0] : cmd_tid;
  always_comb begin
    if (rot)         app_list = LW'(lvl_cur);
    else if (enq_ok) app_list = LW'(cmd_prio);
    else if (blk_ok) app_list = WAITL;
    else             app_list = LW'(prio_q[cmd_tid]);
  end

  tsched_lists #(.NT(NT), .NP(NP)) lists_i (
    .clk(clk), .rst(rst),
    .unl_en(unl_en), .unl_id(mv_id),
    .app_en(app_en), .app_id(mv_id), .app_list(app_list),
    .hd_o(hd), .hn_o(hn), .loc_o(loc)
  );

  tsched_pick #(.NP(NP), .PW(PW)) pick_cur_i (
    .heads(hd), .sel(sel_cur), .sel_lvl(lvl_cur));
  tsched_pick #(.NP(NP), .PW(PW)) pick_nxt_i (
    .heads(hn), .sel(sel_nxt), .sel_lvl(lvl_nxt));

  tsched_slice #(.CW(CW), .DEF_SLICE(DEF_SLICE)) slice_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_len(cfg_slice),
    .reload(do_sw), .expired(expired));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NT; i++) prio_q[i] <= '0;
      next_q <= NULLP;
      run_q  <= NULLP;
      sw_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (enq_ok) prio_q[cmd_tid] <= cmd_prio;
      next_q <= sel_nxt;
      if (do_sw) run_q <= sel_cur;
      sw_q  <= do_sw;
      err_q <= err_q | enq_dup;
    end
  end

  assign next_tid   = {{(NEXT_W-PW){1'b0}}, next_q};
  assign run_tid    = run_q;
  assign ctx_switch = sw_q;
  assign dup_err    = err_q;

  // R5: the dispatched thread is the one the preview showed
  a_r5_dispatch_preview: assert property (@(posedge clk) disable iff (rst)
    ctx_switch |-> run_tid == $past(next_tid[PW-1:0]));
  // R11: a command edge is never a switch edge
  a_r11_cmd_defers: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !ctx_switch);
  // R10: the duplicate flag is sticky
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
    dup_err |=> dup_err);
  // R8: a waiting thread is never previewed
  a_r8_no_blocked_pick: assert property (@(posedge clk) disable iff (rst)
    (next_q != NULLP) |-> (loc[next_q[IW-1:0]] != WAITL));
  // R3: preview never names a thread outside every list
  a_r3_pick_listed: assert property (@(posedge clk) disable iff (rst)
    (next_q != NULLP) |-> (loc[next_q[IW-1:0]] != NOLOC));
endmodule

// File: tb/prio_list_sched_tb_top.sv
module prio_list_sched_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [3:0] cmd_tid = 4'd0;
  logic [1:0] cmd_prio = 2'd0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_slice = 8'd0;
  logic       irq = 1'b0;
  logic [31:0] next_tid;
  logic [4:0]  run_tid;
  logic        ctx_switch, dup_err;

  always #4 clk = ~clk;  // 125 MHz

  prio_list_sched dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_tid(cmd_tid), .cmd_prio(cmd_prio), .cfg_we(cfg_we),
    .cfg_slice(cfg_slice), .irq(irq), .next_tid(next_tid),
    .run_tid(run_tid), .ctx_switch(ctx_switch), .dup_err(dup_err));

  int checks = 0;
  int errors = 0;

  // ---------------- behavioural reference ----------------
  int m_q [5][$];
  int m_loc [16];
  int m_prio [16];
  int m_run, m_next, m_cnt, m_len;
  bit m_sw, m_err, m_live;

  function automatic int m_sel();
    for (int l = 0; l < 4; l++) if (m_q[l].size() > 0) return m_q[l][0];
    return 31;
  endfunction

  function automatic void m_remove(int l, int id);
    for (int i = 0; i < m_q[l].size(); i++)
      if (m_q[l][i] == id) begin m_q[l].delete(i); break; end
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int l = 0; l < 5; l++) m_q[l].delete();
      for (int i = 0; i < 16; i++) begin m_loc[i] = -1; m_prio[i] = 0; end
      m_run = 31; m_next = 31; m_cnt = 0; m_len = 8; m_sw = 0; m_err = 0;
      m_live = 1;
    end else begin
      bit sw;
      sw = (m_cnt == 0 || irq) && !cmd_valid;   // R7, R11
      if (sw) begin
        int s;
        s = m_sel();
        m_run = s;
        if (s != 31) begin                      // R6
          int l;
          l = m_loc[s];
          void'(m_q[l].pop_front());
          m_q[l].push_back(s);
        end
        m_cnt = (m_len == 0) ? 0 : m_len - 1;   // R5
      end else if (m_cnt > 0) m_cnt--;
      if (cfg_we) m_len = cfg_slice;
      if (cmd_valid) begin
        int id;
        id = cmd_tid;
        case (cmd_op)
          2'b00: if (m_loc[id] == -1) begin      // R2
                   m_q[cmd_prio].push_back(id);
                   m_loc[id] = cmd_prio; m_prio[id] = cmd_prio;
                 end else m_err = 1;             // R10
          2'b01: if (m_loc[id] >= 0 && m_loc[id] < 4) begin  // R8
                   m_remove(m_loc[id], id);
                   m_q[4].push_back(id); m_loc[id] = 4;
                 end
          2'b10: if (m_loc[id] == 4) begin       // R9
                   m_remove(4, id);
                   m_q[m_prio[id]].push_back(id); m_loc[id] = m_prio[id];
                 end
          default: ;                             // R12
        endcase
      end
      m_next = m_sel();                          // R3, R4
      m_sw = sw;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && m_live) begin
      chk(next_tid == 32'(m_next), "R4 next_tid", int'(next_tid), m_next);
      chk(run_tid == 5'(m_run), "R6 run_tid", int'(run_tid), m_run);
      chk(ctx_switch == m_sw, "R5 ctx_switch", int'(ctx_switch), int'(m_sw));
      chk(dup_err == m_err, "R10 dup_err", int'(dup_err), int'(m_err));
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input logic [1:0] op, input int id, input int pr);
    cmd_valid = 1'b1; cmd_op = op; cmd_tid = 4'(id); cmd_prio = 2'(pr);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_switch();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (ctx_switch) break;
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: state right after reset (before the first live edge)
    chk(next_tid == 32'h1F, "R1 next_tid", int'(next_tid), 31);
    chk(run_tid == 5'h1F, "R1 run_tid", int'(run_tid), 31);
    chk(dup_err == 1'b0, "R1 dup_err", int'(dup_err), 0);
    cfg_we = 1'b1; cfg_slice = 8'd4; @(negedge clk); cfg_we = 1'b0;
    send(2'b00, 5, 2); send(2'b00, 3, 3); send(2'b00, 7, 2); send(2'b00, 9, 1);
    chk(next_tid == 32'd9, "R3 most urgent", int'(next_tid), 9);
    wait_switch();
    chk(run_tid == 5'd9, "R5 dispatch", int'(run_tid), 9);
    send(2'b00, 2, 0);
    chk(next_tid == 32'd2, "R4 preview", int'(next_tid), 2);
    chk(run_tid == 5'd9, "R7 no early switch", int'(run_tid), 9);
    irq = 1'b1; @(negedge clk); irq = 1'b0;
    chk(ctx_switch == 1'b1, "R7 irq switch", int'(ctx_switch), 1);
    chk(run_tid == 5'd2, "R7 irq dispatch", int'(run_tid), 2);
    send(2'b01, 2, 0);
    chk(next_tid == 32'd9, "R8 blocked skipped", int'(next_tid), 9);
    send(2'b01, 9, 0);
    chk(next_tid == 32'd5, "R8 level 2 head", int'(next_tid), 5);
    send(2'b01, 5, 0);
    chk(next_tid == 32'd7, "R8 unlink head", int'(next_tid), 7);
    send(2'b10, 9, 0);
    chk(next_tid == 32'd9, "R9 unblock level", int'(next_tid), 9);
    send(2'b10, 9, 0);
    chk(next_tid == 32'd9, "R9 ignored unblock", int'(next_tid), 9);
    send(2'b11, 3, 0);
    chk(next_tid == 32'd9, "R12 no-op", int'(next_tid), 9);
    send(2'b00, 7, 0);
    chk(dup_err == 1'b1, "R10 duplicate", int'(dup_err), 1);
    chk(next_tid == 32'd9, "R10 lists unchanged", int'(next_tid), 9);
    send(2'b10, 5, 0); send(2'b10, 2, 0);
    cfg_we = 1'b1; cfg_slice = 8'd0; @(negedge clk); cfg_we = 1'b0;
    repeat (12) @(negedge clk);  // R5 zero length, R6 rotation via model
    // pseudo-random phase (R2, R8, R9, R11 under mixed traffic)
    lfsr = 16'hACE1;
    for (int c = 0; c < 4000; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cmd_valid = lfsr[0] & lfsr[5];
      cmd_op = lfsr[2:1];
      cmd_tid = lfsr[9:6];
      cmd_prio = lfsr[11:10];
      irq = (lfsr[15:12] == 4'hF);
      cfg_we = (lfsr[15:10] == 6'h2A);
      cfg_slice = {5'd0, lfsr[4:2]};
      @(negedge clk);
    end
    cmd_valid = 1'b0; irq = 1'b0; cfg_we = 1'b0;
    @(negedge clk);
    rst = 1'b1; @(negedge clk); @(negedge clk); rst = 1'b0;
    chk(dup_err == 1'b0, "R1 err cleared", int'(dup_err), 0);
    chk(next_tid == 32'h1F, "R1 lists cleared", int'(next_tid), 31);
    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule